// File: doc/BRIEF.md
# Serial Clock-Chip Slave

This block is the slave end of a three-wire serial link to a small clock chip. A host drives three lines: a transaction-enable level, a serial clock and a data bit. The data bit is split into an input, an output and an output-enable. While the enable is high, every falling edge of the serial clock shifts in one bit, most significant bit first. The first eight edges build a command byte and the next eight build a value byte.

Commands give access to 32 bytes of battery-backed RAM, a status register, a control register and six calendar fields. The calendar fields arrive as binary values on input ports and are read back as two BCD digits. For a read command, the slave drives the selected byte onto the data output during the second byte, one bit per edge. A write, and the write that clears the status flags, take effect only on the sixteenth edge. A one-cycle pulse tells the interrupt logic to drop the matching request. Lowering the enable at any time aborts the transaction.

The transfer sequencer has four named states:
- `ST_IDLE`: the enable is low.
- `ST_CMD`: command bits are shifting in.
- `ST_DATA`: value bits are shifting in and read data is driven.
- `ST_DONE`: sixteen bits have been taken and further edges are ignored.

Its transitions:
- `ST_IDLE` to `ST_CMD` when the enable rises.
- `ST_CMD` to `ST_DATA` on the eighth edge.
- `ST_DATA` to `ST_DONE` on the sixteenth edge, which is also the commit.
- Any state to `ST_IDLE` when the enable is low.

Top module: `rtc_slave`

## Requirements
- R1: A bit is taken only in a cycle where `xfer_en` is high, `ser_clk` is low, and `ser_clk` was high in the previous sampled cycle. No other cycle advances the transfer.
- R2: The first eight taken bits form the command, first bit in the MSB position. The next eight form the value byte in the same order. A command that selects nothing readable never raises `ser_doe`.
- R3: Commands 0x00 to 0x1F read RAM byte [command]. On the k-th value edge (k = 0..7), `ser_dout` is registered with bit 7-k of that byte, and `ser_doe` goes high. Both hold until the enable drops.
- R4: Command 0x30 reads the status register and command 0x31 reads the control register, in the same bit order as R3.
- R5: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return seconds, minutes, hours, day of month, month and two-digit year as two BCD digits (tens in bits 7:4). Every other command from 0x20 to 0x2F returns 0x00.
- R6: Commands 0x80 to 0x9F store the value byte into RAM byte (command - 0x80), on the sixteenth edge only.
- R7: Command 0xB1 whose value has bit 2 set clears status bits 4 and 3 on the sixteenth edge. In the following cycle `flag_clr` is high for exactly one cycle. If value bit 2 is clear, nothing changes.
- R8: With `xfer_en` low, the transfer aborts: the bit count, command and value return to zero, nothing is written, and in the next cycle `ser_doe` and `ser_dout` are 0. This includes the case where the enable falls in the same cycle as the sixteenth edge.
- R9: After reset, the status register reads 0x90, the control register reads `CTRL_INIT`, and RAM byte i reads `RAM_INIT[8i+7:8i]`.
- R10: Edges after the sixteenth are ignored until the enable drops: no RAM or status change, and `ser_dout` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_en | input | 1 | Transaction enable from the host |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data driven by the slave |
| ser_doe | output | 1 | High while the slave drives the data line |
| tm_sec | input | 7 | Seconds, binary 0..59 |
| tm_min | input | 7 | Minutes, binary 0..59 |
| tm_hour | input | 7 | Hours, binary 0..23 |
| tm_mday | input | 7 | Day of month, binary 1..31 |
| tm_month | input | 7 | Month, binary 1..12 |
| tm_year | input | 7 | Two-digit year, binary 0..99 |
| flag_clr | output | 1 | One-cycle pulse that clears the matching interrupt request |

## Verification
Two events can land in the same system cycle:
- The enable falling together with a serial clock fall.
- The sixteenth, committing edge together with that same abort.

The bench provokes the second case by lowering `xfer_en` and `ser_clk` on the same half-cycle at the end of a RAM write. It then reads the location back and expects the old contents, because the abort takes precedence. A behavioural model is compared against `ser_dout`, `ser_doe` and `flag_clr` on every clock. This also covers edges sent after the sixteenth, and the first edge arriving in the cycle the enable rises.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_DONE
    } rtc_state_e;

    localparam logic [7:0] CMD_STATUS  = 8'h30;
    localparam logic [7:0] CMD_CONTROL = 8'h31;
    localparam logic [7:0] CMD_CLEAR   = 8'hB1;
    localparam logic [7:0] CMD_WR_BASE = 8'h80;
    localparam int         CLEAR_BIT   = 2;

    function automatic logic [7:0] to_bcd(input logic [6:0] bin);
        return {4'(bin / 7'd10), 4'(bin % 7'd10)};
    endfunction

endpackage

// File: rtl/rtc_serial_fsm.sv
module rtc_serial_fsm
    import rtc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_en,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic [BYTE_W-1:0] cmd_q,
    output logic              data_edge,
    output logic [$clog2(BYTE_W)-1:0] bit_idx,
    output logic              commit,
    output logic [BYTE_W-1:0] commit_val
);
    localparam int CW = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    rtc_state_e        state_q, state_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic [BYTE_W-1:0] cmd_n, val_q, val_n;
    logic              clk_prev_q;
    logic              fall;

    assign fall       = xfer_en & clk_prev_q & ~ser_clk;
    assign bit_idx    = cnt_q;
    assign commit_val = {val_q[BYTE_W-2:0], ser_din};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            cmd_q      <= '0;
            val_q      <= '0;
            clk_prev_q <= 1'b0;
        end else begin
            state_q    <= state_n;
            cnt_q      <= cnt_n;
            cmd_q      <= cmd_n;
            val_q      <= val_n;
            clk_prev_q <= ser_clk;
        end
    end

    always_comb begin
        state_n   = state_q;
        cnt_n     = cnt_q;
        cmd_n     = cmd_q;
        val_n     = val_q;
        data_edge = 1'b0;
        commit    = 1'b0;
        if (!xfer_en) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
            cmd_n   = '0;
            val_n   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_CMD: begin
                    state_n = ST_CMD;
                    if (fall) begin
                        cmd_n = {cmd_q[BYTE_W-2:0], ser_din};
                        cnt_n = cnt_q + 1'b1;
                        if (cnt_q == LAST) state_n = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (fall) begin
                        val_n     = commit_val;
                        data_edge = 1'b1;
                        cnt_n     = cnt_q + 1'b1;
                        if (cnt_q == LAST) begin
                            state_n = ST_DONE;
                            commit  = 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    state_n = ST_DONE;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int                    RAM_BYTES   = 32,
    parameter logic [RAM_BYTES*8-1:0] RAM_INIT   = '0,
    parameter logic [7:0]            STATUS_INIT = 8'h90,
    parameter logic [7:0]            CTRL_INIT   = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cmd,
    input  logic       commit,
    input  logic [7:0] commit_val,
    input  logic [6:0] tm_sec,
    input  logic [6:0] tm_min,
    input  logic [6:0] tm_hour,
    input  logic [6:0] tm_mday,
    input  logic [6:0] tm_month,
    input  logic [6:0] tm_year,
    output logic [7:0] rd_byte,
    output logic       rd_ok,
    output logic       clr_q
);
    localparam int         AW    = $clog2(RAM_BYTES);
    localparam logic [7:0] RAM_N = 8'(RAM_BYTES);

    logic [7:0] ram_q [RAM_BYTES];
    logic [7:0] status_q;
    logic [7:0] wr_off;
    logic       wr_hit;
    logic       clr_hit;

    assign wr_off  = cmd - CMD_WR_BASE;
    assign wr_hit  = commit && (cmd >= CMD_WR_BASE) && (wr_off < RAM_N);
    assign clr_hit = commit && (cmd == CMD_CLEAR) && commit_val[CLEAR_BIT];

    for (genvar i = 0; i < RAM_BYTES; i++) begin : g_ram
        always_ff @(posedge clk) begin
            if (!rst_n)
                ram_q[i] <= RAM_INIT[i*8 +: 8];
            else if (wr_hit && (wr_off == 8'(i)))
                ram_q[i] <= commit_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= STATUS_INIT;
            clr_q    <= 1'b0;
        end else begin
            clr_q <= clr_hit;
            if (clr_hit) status_q[4:3] <= 2'b00;
        end
    end

    always_comb begin
        rd_ok   = 1'b1;
        rd_byte = 8'h00;
        if (cmd < RAM_N) begin
            rd_byte = ram_q[cmd[AW-1:0]];
        end else if (cmd == CMD_STATUS) begin
            rd_byte = status_q;
        end else if (cmd == CMD_CONTROL) begin
            rd_byte = CTRL_INIT;
        end else if (cmd[7:4] == 4'h2) begin
            unique case (cmd[3:0])
                4'h0:    rd_byte = to_bcd(tm_sec);
                4'h1:    rd_byte = to_bcd(tm_min);
                4'h2:    rd_byte = to_bcd(tm_hour);
                4'h4:    rd_byte = to_bcd(tm_mday);
                4'h5:    rd_byte = to_bcd(tm_month);
                4'h6:    rd_byte = to_bcd(tm_year);
                default: rd_byte = 8'h00;
            endcase
        end else begin
            rd_ok = 1'b0;
        end
    end

endmodule

// File: rtl/rtc_slave.sv
module rtc_slave
    import rtc_pkg::*;
#(
    parameter int                     RAM_BYTES   = 32,
    parameter logic [RAM_BYTES*8-1:0] RAM_INIT    = '0,
    parameter logic [7:0]             STATUS_INIT = 8'h90,
    parameter logic [7:0]             CTRL_INIT   = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_en,
    input  logic       ser_clk,
    input  logic       ser_din,
    output logic       ser_dout,
    output logic       ser_doe,
    input  logic [6:0] tm_sec,
    input  logic [6:0] tm_min,
    input  logic [6:0] tm_hour,
    input  logic [6:0] tm_mday,
    input  logic [6:0] tm_month,
    input  logic [6:0] tm_year,
    output logic       flag_clr
);
    logic [7:0] cmd_q;
    logic       data_edge;
    logic [2:0] bit_idx;
    logic       commit;
    logic [7:0] commit_val;
    logic [7:0] rd_byte;
    logic       rd_ok;

    rtc_serial_fsm #(.BYTE_W(8)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_en    (xfer_en),
        .ser_clk    (ser_clk),
        .ser_din    (ser_din),
        .cmd_q      (cmd_q),
        .data_edge  (data_edge),
        .bit_idx    (bit_idx),
        .commit     (commit),
        .commit_val (commit_val)
    );

    rtc_regfile #(
        .RAM_BYTES   (RAM_BYTES),
        .RAM_INIT    (RAM_INIT),
        .STATUS_INIT (STATUS_INIT),
        .CTRL_INIT   (CTRL_INIT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd_q),
        .commit     (commit),
        .commit_val (commit_val),
        .tm_sec     (tm_sec),
        .tm_min     (tm_min),
        .tm_hour    (tm_hour),
        .tm_mday    (tm_mday),
        .tm_month   (tm_month),
        .tm_year    (tm_year),
        .rd_byte    (rd_byte),
        .rd_ok      (rd_ok),
        .clr_q      (flag_clr)
    );

    // Output process: drive one read bit per value edge, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n || !xfer_en) begin
            ser_dout <= 1'b0;
            ser_doe  <= 1'b0;
        end else if (data_edge && rd_ok) begin
            ser_dout <= rd_byte[3'd7 - bit_idx];
            ser_doe  <= 1'b1;
        end
    end

endmodule

// File: rtl/rtc_slave_checker.sv
module rtc_slave_checker (
    input logic clk,
    input logic rst_n,
    input logic xfer_en,
    input logic ser_clk,
    input logic ser_doe,
    input logic ser_dout,
    input logic flag_clr
);
    // R8: an inactive enable leaves the data line undriven next cycle
    a_r8_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> (!ser_doe && !ser_dout));

    // R7: the clear pulse lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !flag_clr);

    // R1: driving starts only from a cycle that saw a low serial clock
    a_r1_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_doe) |-> $past(xfer_en && !ser_clk));

    // R3: the slave drives only while the previous cycle had the enable high
    a_r3_drive_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        ser_doe |-> $past(xfer_en));
endmodule

bind rtc_slave rtc_slave_checker u_rtc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_en  (xfer_en),
    .ser_clk  (ser_clk),
    .ser_doe  (ser_doe),
    .ser_dout (ser_dout),
    .flag_clr (flag_clr)
);

// File: tb/rtc_slave_bench.sv
`timescale 1ns/1ps
module rtc_slave_bench;
    localparam int         NB     = 32;
    localparam logic [7:0] CTRL_V = 8'h5C;

    function automatic logic [NB*8-1:0] mk_init();
        logic [NB*8-1:0] r;
        for (int i = 0; i < NB; i++) r[i*8 +: 8] = 8'(i * 37 + 11);
        return r;
    endfunction
    localparam logic [NB*8-1:0] INIT = mk_init();

    logic clk = 0, rst_n = 0, sel = 0, sc = 0, sd = 0;
    logic [6:0] t_sec = 0, t_min = 0, t_hour = 0, t_mday = 1, t_mon = 1, t_yr = 0;
    logic dout, doe, clr;

    rtc_slave #(.RAM_BYTES(NB), .RAM_INIT(INIT), .STATUS_INIT(8'h90), .CTRL_INIT(CTRL_V)) u_rtc_slave (
        .clk(clk), .rst_n(rst_n), .xfer_en(sel), .ser_clk(sc), .ser_din(sd),
        .ser_dout(dout), .ser_doe(doe),
        .tm_sec(t_sec), .tm_min(t_min), .tm_hour(t_hour),
        .tm_mday(t_mday), .tm_month(t_mon), .tm_year(t_yr),
        .flag_clr(clr)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0, n_pulse = 0;

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   ph = -1, m_cmd = 0, m_val = 0, m_status = 'h90;
    int   m_ram [NB];
    logic m_dout = 0, m_doe = 0, m_clr = 0, m_prev = 0;

    function automatic int bcd(int x);
        return (x / 10) * 16 + x % 10;
    endfunction

    function automatic int m_byte(int c);
        if (c < NB) return m_ram[c];
        if (c == 'h30) return m_status;
        if (c == 'h31) return int'(CTRL_V);
        if (c >= 'h20 && c <= 'h2F) begin
            case (c)
                'h20: return bcd(int'(t_sec));
                'h21: return bcd(int'(t_min));
                'h22: return bcd(int'(t_hour));
                'h24: return bcd(int'(t_mday));
                'h25: return bcd(int'(t_mon));
                'h26: return bcd(int'(t_yr));
                default: return 0;
            endcase
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = -1; m_cmd = 0; m_val = 0; m_status = 'h90;
            m_dout = 0; m_doe = 0; m_clr = 0; m_prev = 0;
            for (int i = 0; i < NB; i++) m_ram[i] = int'(INIT[i*8 +: 8]);
        end else begin
            m_clr = 0;
            if (!sel) begin
                ph = -1; m_cmd = 0; m_val = 0; m_doe = 0; m_dout = 0;
            end else begin
                if (ph < 0) ph = 0;
                if (m_prev && !sc && ph < 16) begin
                    if (ph < 8) m_cmd = ((m_cmd << 1) | int'(sd)) & 255;
                    else begin
                        int b;
                        m_val = ((m_val << 1) | int'(sd)) & 255;
                        b = m_byte(m_cmd);
                        if (b >= 0) begin
                            m_dout = ((b >> (15 - ph)) & 1) != 0;
                            m_doe  = 1;
                        end
                    end
                    ph++;
                    if (ph == 16) begin
                        if (m_cmd >= 128 && m_cmd < 128 + NB) m_ram[m_cmd - 128] = m_val;
                        if (m_cmd == 'hB1 && (m_val & 4) != 0) begin
                            m_status = m_status & ~'h18;
                            m_clr = 1;
                        end
                    end
                end
            end
            m_prev = sc;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 R4 R5 per-cycle ser_dout", int'(dout), int'(m_dout));
            check("R2 R8 per-cycle ser_doe", int'(doe), int'(m_doe));
            check("R7 per-cycle flag_clr", int'(clr), int'(m_clr));
            if (clr) n_pulse++;
        end
    end

    // ---------------- host transaction ----------------
    task automatic xact(input logic [7:0] c, input logic [7:0] v, input int nbits,
                        input int extra, input bit drop_last, output logic [7:0] rb);
        rb = 8'h00;
        @(negedge clk) sel = 1;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sc = 1;
            sd = (i < 8) ? c[7 - i] : v[15 - i];
            @(negedge clk);
            sc = 0;
            if (drop_last && i == nbits - 1) sel = 0;
            @(negedge clk);
            if (i >= 8) rb = {rb[6:0], dout};
        end
        for (int j = 0; j < extra; j++) begin
            @(negedge clk); sc = 1; sd = ~sd;
            @(negedge clk); sc = 0;
            @(negedge clk);
            if (doe) rb = {rb[6:0], dout};
        end
        @(negedge clk) sel = 0;
        @(negedge clk);
    endtask

    logic [7:0] rb;

    initial begin
        repeat (4) @(negedge clk);
        check("R9 ser_doe after reset", int'(doe), 0);
        check("R9 ser_dout after reset", int'(dout), 0);
        rst_n = 1;

        xact(8'h30, 8'h00, 16, 0, 0, rb); check("R9 R4 status reset value", rb, 'h90);
        xact(8'h31, 8'h00, 16, 0, 0, rb); check("R4 control value", rb, int'(CTRL_V));
        xact(8'h00, 8'h00, 16, 0, 0, rb); check("R3 R9 RAM byte 0", rb, int'(INIT[7:0]));
        xact(8'h1F, 8'h00, 16, 0, 0, rb); check("R3 R9 RAM byte 31", rb, int'(INIT[255:248]));

        xact(8'h85, 8'hA7, 16, 0, 0, rb);
        xact(8'h05, 8'h00, 16, 0, 0, rb); check("R6 write then read byte 5", rb, 'hA7);

        xact(8'h86, 8'h3C, 12, 0, 0, rb);
        xact(8'h06, 8'h00, 16, 0, 0, rb); check("R8 short write aborted", rb, int'(INIT[55:48]));
        xact(8'h86, 8'h3C, 16, 0, 1, rb);
        xact(8'h06, 8'h00, 16, 0, 0, rb); check("R8 abort on committing edge", rb, int'(INIT[55:48]));

        xact(8'h81, 8'h11, 16, 5, 0, rb);
        xact(8'h01, 8'h00, 16, 0, 0, rb); check("R10 extra edges after write", rb, 'h11);
        xact(8'h02, 8'h00, 16, 3, 0, rb);
        check("R10 dout holds last bit", rb, ((int'(INIT[23:16]) << 3) | ((int'(INIT[16]) != 0) ? 7 : 0)) & 255);

        xact(8'h40, 8'h00, 16, 0, 0, rb); check("R2 unreadable command stays low", rb, 0);

        t_sec = 59; t_min = 7; t_hour = 23; t_mday = 31; t_mon = 12; t_yr = 99;
        xact(8'h20, 8'h00, 16, 0, 0, rb); check("R5 seconds BCD", rb, 'h59);
        xact(8'h21, 8'h00, 16, 0, 0, rb); check("R5 minutes BCD", rb, 'h07);
        xact(8'h22, 8'h00, 16, 0, 0, rb); check("R5 hours BCD", rb, 'h23);
        xact(8'h23, 8'h00, 16, 0, 0, rb); check("R5 unused time slot", rb, 'h00);
        xact(8'h24, 8'h00, 16, 0, 0, rb); check("R5 day BCD", rb, 'h31);
        xact(8'h25, 8'h00, 16, 0, 0, rb); check("R5 month BCD", rb, 'h12);
        xact(8'h26, 8'h00, 16, 0, 0, rb); check("R5 year BCD", rb, 'h99);
        xact(8'h2F, 8'h00, 16, 0, 0, rb); check("R5 top time slot", rb, 'h00);

        xact(8'hB1, 8'hFB, 16, 0, 0, rb);
        xact(8'h30, 8'h00, 16, 0, 0, rb); check("R7 clear without bit 2", rb, 'h90);
        check("R7 no pulse without bit 2", n_pulse, 0);
        xact(8'hB1, 8'h04, 16, 0, 0, rb);
        check("R7 one pulse", n_pulse, 1);
        xact(8'h30, 8'h00, 16, 0, 0, rb); check("R7 status flags cleared", rb, 'h80);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule